// File: doc/BRIEF.md
# Receive-Only Two-Wire Control Slave

This block is the listening end of a two-wire serial control bus. A host microcontroller drives the clock line and the data line. The block samples both lines with a fast local system clock and passes each one through a synchronizer and a glitch filter. From the filtered lines it recognises bus start and stop conditions and shifts in bits most significant first.

The first byte after every start is an address byte. The block answers only to the pattern `1101_10X0`, where X is taken from the `addr_sel` strap pin. On a match it pulls the data line low for the ninth clock pulse as its acknowledge. It then takes any number of data bytes and acknowledges each one. Each data byte appears on a parallel port together with a single-cycle strobe and a running byte index. The index restarts at zero after every start condition.

The data line is open-drain. The block never drives it high: `sda_pull` high means "pull the line low". The system clock must run at least 16 times faster than the bus clock, and the bus clock is at most 400 kHz.

Top module: `i2cw_slave`

## Requirements
- R1: After reset `sda_pull` is 0, `rx_valid` is 0 and `rx_index` is 0.
- R2: The address byte matches only when all 8 bits equal 1101_10X0 (the first bit on the bus is bit 7), with X equal to `addr_sel`. On a match, `sda_pull` is high throughout the high phase of the ninth SCL pulse.
- R3: After an address byte that does not match, including one whose last bit (the read/write bit) is 1, the block asserts neither `sda_pull` nor `rx_valid` until the next start condition.
- R4: Each data byte after a matched address is acknowledged. The byte appears on `rx_byte` with bit 7 being the first bit received, and `rx_valid` is high for exactly one system-clock cycle per byte.
- R5: `sda_pull` changes only while the filtered SCL is low.
- R6: `rx_index` reads 0 for the first data byte after a start and increases by 1 for each later byte.
- R7: A stop condition (SDA rising while SCL is high) returns the block to idle. Bytes clocked after a stop and without a new start get no acknowledge and no `rx_valid`.
- R8: A pulse on SCL shorter than the filter length (3 system cycles) is ignored and does not disturb the received byte.
- R9: A start condition (SDA falling while SCL is high) that arrives with no stop before it acts as a fresh start: the next byte is an address and the index restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as sampled from the pad |
| sda_in | input | 1 | Bus data line as sampled from the pad |
| addr_sel | input | 1 | Strap that sets address bit 1 |
| sda_pull | output | 1 | 1 = pull the data line low (open-drain enable) |
| rx_byte | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe when `rx_byte` is new |
| rx_index | output | 4 | Position of the byte since the last start |

## Verification
The bench drives the address pattern with both strap levels. It also sends near-miss addresses: the other strap value, and the read bit set. A design that compared too few bits would acknowledge one of these. After a rejected address it keeps clocking data, which catches a slave that wakes up again before the next start. A stop followed by clocked bytes with no start exposes a slave that stays live after a stop. A repeated start in the middle of a byte stream checks that the index goes back to zero. Single-cycle SCL dips inside the high phase would add extra bits to a design with no filter. A monitor also watches for `rx_valid` pulses wider than one cycle and for the acknowledge drive changing while SCL is high.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [5:0] ADDR_TOP = 6'b110110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/i2cw_glitch_filter.sv
module i2cw_glitch_filter #(
  parameter int   FILT_LEN = 3,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                out_q, out_n;

  always_comb begin
    out_n = out_q;
    if (&hist_q)       out_n = 1'b1;
    else if (~|hist_q) out_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{RST_VAL}};
      hist_q <= {FILT_LEN{RST_VAL}};
      out_q  <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], din};
      hist_q <= FILT_LEN'({hist_q, sync_q[1]});
      out_q  <= out_n;
    end
  end

  assign dout = out_q;

  // R8
  filt_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> out_q == $past(sync_q[1], 2));
endmodule

// File: rtl/i2cw_cond_detect.sv
module i2cw_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2cw_rx_fsm.sv
module i2cw_rx_fsm
  import i2cw_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              addr_sel,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic [IDX_W-1:0]  rx_index
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  rx_state_e         st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n, byte_q, byte_n;
  logic              vld_q, vld_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              addr_ok;

  assign addr_ok = (sh_q == {ADDR_TOP, addr_sel, 1'b0});

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    byte_n = byte_q;
    vld_n  = 1'b0;
    idx_n  = vld_q ? idx_q + 1'b1 : idx_q;
    if (start_evt) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      idx_n = '0;
    end else if (stop_evt) begin
      st_n = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise && cnt_q != FULL) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_f};
            cnt_n = cnt_q + 1'b1;
          end
          if (scl_fall && cnt_q == FULL) begin
            if (st_q == ST_ADDR) begin
              st_n = addr_ok ? ST_AACK : ST_SKIP;
            end else begin
              st_n   = ST_DACK;
              byte_n = sh_q;
              vld_n  = 1'b1;
            end
          end
        end
        ST_AACK, ST_DACK: begin
          if (scl_fall) begin
            st_n  = ST_DATA;
            cnt_n = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      byte_q <= byte_n;
      vld_q  <= vld_n;
      idx_q  <= idx_n;
    end
  end

  assign sda_pull = (st_q == ST_AACK) || (st_q == ST_DACK);
  assign rx_byte  = byte_q;
  assign rx_valid = vld_q;
  assign rx_index = idx_q;

  // R4
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R5
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_f);
  // R6
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !start_evt) |=> rx_index == $past(rx_index) + 1'b1);
  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (rx_index == '0 && !sda_pull));
endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave
  import i2cw_pkg::*;
#(
  parameter int FILT_LEN = 3,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              addr_sel,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic [IDX_W-1:0]  rx_index
);
  logic [1:0] rst_q;
  logic       rst_sync_n;
  logic [1:0] raw, filt;
  logic       scl_rise, scl_fall, start_evt, stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2cw_glitch_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) i_filt (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .din  (raw[g]),
      .dout (filt[g])
    );
  end

  i2cw_cond_detect i_cond (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_f    (filt[1]),
    .sda_f    (filt[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  i2cw_rx_fsm #(.IDX_W(IDX_W)) i_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_f    (filt[1]),
    .sda_f    (filt[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .addr_sel (addr_sel),
    .sda_pull (sda_pull),
    .rx_byte  (rx_byte),
    .rx_valid (rx_valid),
    .rx_index (rx_index)
  );
endmodule

// File: tb/test_i2cw_slave.sv
module test_i2cw_slave;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       addr_sel = 1'b0;
  logic       glitch = 1'b0;
  logic       sda_pull, rx_valid;
  logic [7:0] rx_byte;
  logic [3:0] rx_index;
  logic       sda_line;

  int checks = 0;
  int errors = 0;
  int ntot = 0;
  int wide = 0;
  int pull_hi_chg = 0;
  logic [7:0] got_b [0:63];
  logic [3:0] got_i [0:63];
  logic prev_vld = 1'b0;
  logic prev_pull = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2cw_slave i_i2cw_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .addr_sel(addr_sel), .sda_pull(sda_pull), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .rx_index(rx_index)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        if (ntot < 64) begin
          got_b[ntot] = rx_byte;
          got_i[ntot] = rx_index;
        end
        ntot = ntot + 1;
      end
      if (rx_valid && prev_vld) wide = wide + 1;
      if (sda_pull != prev_pull && scl_m) pull_hi_chg = pull_hi_chg + 1;
    end
    prev_vld  = rx_valid;
    prev_pull = sda_pull;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(2 * Q);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    scl_m = 1'b0; wait_clk(Q);
    sda_m = b;    wait_clk(Q);
    scl_m = 1'b1;
    if (glitch) begin
      wait_clk(3); scl_m = 1'b0; wait_clk(1); scl_m = 1'b1; wait_clk(Q - 4);
    end else begin
      wait_clk(Q);
    end
    @(negedge clk); seen = sda_line;
    wait_clk(Q);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
    bus_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic t_reset();
    check("R1 pull", int'(sda_pull), 0);
    check("R1 valid", int'(rx_valid), 0);
    check("R1 index", int'(rx_index), 0);
  endtask

  task automatic t_match_sel0();
    logic a; int base = ntot;
    addr_sel = 1'b0;
    bus_start();
    send_byte(8'hD8, a); check("R2 ack sel0", int'(a), 1);
    send_byte(8'h5A, a); check("R4 ack data0", int'(a), 1);
    send_byte(8'hA5, a); check("R4 ack data1", int'(a), 1);
    bus_stop();
    check("R4 count", ntot - base, 2);
    check("R4 byte0", int'(got_b[base]), 8'h5A);
    check("R4 byte1", int'(got_b[base + 1]), 8'hA5);
    check("R6 idx0", int'(got_i[base]), 0);
    check("R6 idx1", int'(got_i[base + 1]), 1);
  endtask

  task automatic t_sel1_and_miss();
    logic a; int base = ntot;
    addr_sel = 1'b1;
    bus_start();
    send_byte(8'hD8, a); check("R3 wrong strap nack", int'(a), 0);
    send_byte(8'hFF, a); check("R3 ignored data nack", int'(a), 0);
    send_byte(8'hD8, a); check("R3 ignored data2 nack", int'(a), 0);
    bus_stop();
    check("R3 no valid", ntot - base, 0);
    bus_start();
    send_byte(8'hDA, a); check("R2 ack sel1", int'(a), 1);
    send_byte(8'h3C, a); check("R4 ack sel1 data", int'(a), 1);
    bus_stop();
    check("R4 sel1 count", ntot - base, 1);
    check("R4 sel1 byte", int'(got_b[base]), 8'h3C);
  endtask

  task automatic t_read_bit();
    logic a; int base = ntot;
    addr_sel = 1'b0;
    bus_start();
    send_byte(8'hD9, a); check("R3 read bit nack", int'(a), 0);
    send_byte(8'h11, a); check("R3 after read nack", int'(a), 0);
    bus_stop();
    check("R3 read no valid", ntot - base, 0);
  endtask

  task automatic t_rep_start();
    logic a; int base = ntot;
    addr_sel = 1'b0;
    bus_start();
    send_byte(8'hD8, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    bus_start();
    send_byte(8'hD8, a); check("R9 ack after restart", int'(a), 1);
    send_byte(8'h33, a);
    bus_stop();
    check("R9 count", ntot - base, 3);
    check("R6 idx before restart", int'(got_i[base + 1]), 1);
    check("R9 idx after restart", int'(got_i[base + 2]), 0);
    check("R9 byte after restart", int'(got_b[base + 2]), 8'h33);
  endtask

  task automatic t_stop_idle();
    logic a; int base = ntot;
    addr_sel = 1'b0;
    bus_start();
    send_byte(8'hD8, a);
    bus_stop();
    send_byte(8'h77, a); check("R7 nack after stop", int'(a), 0);
    send_byte(8'hD8, a); check("R7 no addr w/o start", int'(a), 0);
    bus_stop();
    check("R7 no valid", ntot - base, 0);
  endtask

  task automatic t_glitch();
    logic a; int base = ntot;
    addr_sel = 1'b0;
    bus_start();
    send_byte(8'hD8, a);
    glitch = 1'b1;
    send_byte(8'h96, a);
    glitch = 1'b0;
    check("R8 ack with glitches", int'(a), 1);
    bus_stop();
    check("R8 count", ntot - base, 1);
    check("R8 byte", int'(got_b[base]), 8'h96);
  endtask

  initial begin : watchdog
    wait_clk(150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_match_sel0();
    t_sel1_and_miss();
    t_read_bit();
    t_rep_start();
    t_stop_idle();
    t_glitch();
    check("R4 valid width", wide, 0);
    check("R5 pull changed with SCL high", pull_hi_chg, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule